// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps every issued instruction in program order inside a circular buffer. When an instruction issues, it takes the slot at the tail and receives that slot's index as its tag. Functional units later put results on a broadcast bus under that tag. The buffer holds each result until the instruction reaches the head and then retires it. A register operation writes the register file at retirement. A store writes memory at retirement. A mispredicted branch at the head discards every younger instruction and sends out the correct next fetch address.

While results wait for commit, the buffer is also the operand source for younger instructions. A set of lookup ports reads any slot by tag and returns its value and ready bit in the same cycle. A broadcast arriving in that cycle is forwarded to the lookup. A fault reported with a result is kept in the slot. It is raised only when the slot reaches the head, and it is lost if a flush removes the slot first. Stores need no separate buffer: their address is kept from issue and their data from the broadcast.

Top module: `reorder_buffer`

## Requirements
- R1: A granted allocation takes the slot at the tail. `alloc_tag` shows that slot index during the cycle. Tags count upward in program order and wrap modulo DEPTH. Kind encoding on `alloc_kind`: 2'b00 register operation, 2'b01 store, 2'b10 branch.
- R2: When DEPTH slots are occupied, `alloc_ready` is low and `alloc_valid` is ignored: the tail does not move and no slot is written.
- R3: A broadcast (`wb_valid`) whose tag names an occupied slot stores `wb_value`, the mispredict flag and the fault flag in that slot and marks the slot ready.
- R4: Retirement happens only from the head and only when the head slot is ready, with at most one slot per cycle. A ready register operation drives `cm_reg_we` with its destination and value.
- R5: A store drives `cm_mem_we`, with its address in `cm_mem_addr` and its value in `cm_mem_data`, only in the cycle it retires from the head, never earlier.
- R6: A branch that retires with its mispredict flag set drives `flush_valid` with `flush_target` equal to its value. It empties the buffer in that cycle, and no younger slot ever commits. The next allocation receives the tag after the branch.
- R7: A branch that retires without the mispredict flag pulses only `cm_retire`. It makes no register write, no memory write and no flush.
- R8: A slot that retires with its fault flag set drives `exc_valid` with `exc_tag` equal to its index. It makes no register or memory write and empties the buffer. A fault held by a slot that a flush removed is never raised.
- R9: Each lookup port returns the value and ready bit of the slot named by its tag in the same cycle. A broadcast to that slot in the same cycle is forwarded, giving ready 1 and the broadcast value.
- R10: After reset the buffer is empty, `alloc_ready` is 1, `alloc_tag` is 0, and no commit, flush or fault output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Issue requests a slot |
| alloc_kind | input | 2 | Instruction kind of the new slot |
| alloc_dest | input | DEST_W | Register number or store address |
| alloc_ready | output | 1 | A slot can be granted this cycle |
| alloc_tag | output | IDX_W | Tag of the slot being granted |
| wb_valid | input | 1 | Result broadcast present |
| wb_tag | input | IDX_W | Slot the broadcast belongs to |
| wb_value | input | DATA_W | Result, store data or branch successor |
| wb_mispredict | input | 1 | Branch outcome differs from prediction |
| wb_exc | input | 1 | Instruction raised a fault |
| lk_tag | input | NUM_LK x IDX_W | Lookup tags |
| lk_value | output | NUM_LK x DATA_W | Lookup values |
| lk_ready | output | NUM_LK | Lookup ready bits |
| cm_retire | output | 1 | Head slot leaves the buffer this cycle |
| cm_reg_we | output | 1 | Register write at commit |
| cm_reg_dest | output | DEST_W | Register number written |
| cm_reg_data | output | DATA_W | Register value written |
| cm_mem_we | output | 1 | Memory write at commit |
| cm_mem_addr | output | DEST_W | Store address |
| cm_mem_data | output | DATA_W | Store data |
| flush_valid | output | 1 | Mispredict recovery, refetch needed |
| flush_target | output | DATA_W | Correct successor address |
| exc_valid | output | 1 | Precise fault taken |
| exc_tag | output | IDX_W | Slot that faulted |

## Verification
The bench builds the buffer with DEPTH 4, DATA_W 16, DEST_W 8 and two lookup ports. With only four slots, a single program fills the buffer, and the tail pointer wraps more than once in a short run. That brings the full stall and the tag wrap within reach, and it lets a branch flush in one sequence and a fault in the next land at non-zero head positions. With two lookup ports, one port can read a stored result while the other catches a same-cycle forward.

// File: rtl/rob_pkg.sv
// Package: shared kind encoding for the reorder buffer.
// Assumes two bits are enough for the three instruction kinds.
package rob_pkg;
    typedef enum logic [1:0] {
        ROB_REG    = 2'b00,
        ROB_STORE  = 2'b01,
        ROB_BRANCH = 2'b10
    } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
// Module: head and tail pointers, each with one wrap bit.
// Assumes DEPTH is a power of two. A flush also pops the head, and both
// pointers then restart at the slot after the retiring head.
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             full
);
    logic [IDX_W:0] head_q, tail_q;
    logic [IDX_W:0] head_nx;

    // Next head position after a retirement
    assign head_nx = head_q + 1'b1;

    // Pointer update: flush collapses the tail onto the new head
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (clear) begin
            head_q <= head_nx;
            tail_q <= head_nx;
        end else begin
            if (push) tail_q <= tail_q + 1'b1;
            if (pop)  head_q <= head_nx;
        end
    end

    // Full when the indices match and the wrap bits differ
    assign full     = (head_q[IDX_W] != tail_q[IDX_W]) &&
                      (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);
    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
endmodule

// File: rtl/rob_storage.sv
// Module: slot array of the reorder buffer with result capture and
// tag-indexed lookup ports. Only busy slots accept broadcasts.
// Assumes the allocated slot and a broadcast never name the same slot
// in one cycle, since a slot cannot produce a result before it exists.
module rob_storage
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int DEST_W = 32,
    parameter int NUM_LK = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_en,
    input  logic [IDX_W-1:0]              alloc_idx,
    input  rob_kind_e                     alloc_kind,
    input  logic [DEST_W-1:0]             alloc_dest,
    input  logic                          wb_valid,
    input  logic [IDX_W-1:0]              wb_tag,
    input  logic [DATA_W-1:0]             wb_value,
    input  logic                          wb_mispredict,
    input  logic                          wb_exc,
    input  logic                          retire_en,
    input  logic                          clear_all,
    input  logic [IDX_W-1:0]              head_idx,
    input  logic [NUM_LK-1:0][IDX_W-1:0]  lk_tag,
    output logic [NUM_LK-1:0][DATA_W-1:0] lk_value,
    output logic [NUM_LK-1:0]             lk_ready,
    output logic                          head_busy,
    output logic                          head_ready,
    output rob_kind_e                     head_kind,
    output logic [DEST_W-1:0]             head_dest,
    output logic [DATA_W-1:0]             head_value,
    output logic                          head_misp,
    output logic                          head_exc,
    output logic [DEPTH-1:0]              busy_vec
);
    logic [DEPTH-1:0]  busy_q, ready_q, misp_q, exc_q;
    rob_kind_e         kind_q  [DEPTH];
    logic [DEST_W-1:0] dest_q  [DEPTH];
    logic [DATA_W-1:0] value_q [DEPTH];

    // Control bits: occupancy and completion per slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= '0;
            ready_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (clear_all || (retire_en && head_idx == IDX_W'(i))) begin
                    busy_q[i]  <= 1'b0;
                    ready_q[i] <= 1'b0;
                end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
                    busy_q[i]  <= 1'b1;
                    ready_q[i] <= 1'b0;
                end else if (wb_valid && wb_tag == IDX_W'(i) && busy_q[i]) begin
                    ready_q[i] <= 1'b1;
                end
            end
        end
    end

    // Payload: kind and destination at issue, result flags at broadcast
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (alloc_en && alloc_idx == IDX_W'(i)) begin
                kind_q[i] <= alloc_kind;
                dest_q[i] <= alloc_dest;
                misp_q[i] <= 1'b0;
                exc_q[i]  <= 1'b0;
            end else if (wb_valid && wb_tag == IDX_W'(i) && busy_q[i]) begin
                value_q[i] <= wb_value;
                misp_q[i]  <= wb_mispredict;
                exc_q[i]   <= wb_exc;
            end
        end
    end

    // Lookup ports with same-cycle broadcast forwarding
    for (genvar g = 0; g < NUM_LK; g++) begin : g_lk
        logic fwd;
        assign fwd         = wb_valid && (wb_tag == lk_tag[g]) && busy_q[lk_tag[g]];
        assign lk_value[g] = fwd ? wb_value : value_q[lk_tag[g]];
        assign lk_ready[g] = fwd | ready_q[lk_tag[g]];
    end

    // Head slot view for the commit stage
    assign head_busy  = busy_q[head_idx];
    assign head_ready = ready_q[head_idx];
    assign head_kind  = kind_q[head_idx];
    assign head_dest  = dest_q[head_idx];
    assign head_value = value_q[head_idx];
    assign head_misp  = misp_q[head_idx];
    assign head_exc   = exc_q[head_idx];
    assign busy_vec   = busy_q;
endmodule

// File: rtl/rob_commit.sv
// Module: combinational retirement decision for the head slot.
// Assumes the head view is registered state, so no input-to-output path
// exists. A fault outranks every kind-specific action.
module rob_commit
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int DEST_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              head_busy,
    input  logic              head_ready,
    input  rob_kind_e         head_kind,
    input  logic [DEST_W-1:0] head_dest,
    input  logic [DATA_W-1:0] head_value,
    input  logic              head_misp,
    input  logic              head_exc,
    input  logic [IDX_W-1:0]  head_idx,
    output logic              retire,
    output logic              clear,
    output logic              reg_we,
    output logic              mem_we,
    output logic              flush,
    output logic              exc,
    output logic [DEST_W-1:0] dest,
    output logic [DATA_W-1:0] data,
    output logic [IDX_W-1:0]  exc_idx
);
    logic fire;

    // Decode the head slot into exactly one commit action
    always_comb begin
        fire   = head_busy && head_ready;
        exc    = fire && head_exc;
        reg_we = fire && !head_exc && head_kind == ROB_REG;
        mem_we = fire && !head_exc && head_kind == ROB_STORE;
        flush  = fire && !head_exc && head_kind == ROB_BRANCH && head_misp;
        clear  = exc || flush;
        retire = fire;
    end

    assign dest    = head_dest;
    assign data    = head_value;
    assign exc_idx = head_idx;
endmodule

// File: rtl/reorder_buffer.sv
// Module: reorder buffer top. Allocates slots in program order, captures
// broadcast results, serves operand lookups and retires from the head.
// Assumes one allocation and one broadcast per cycle; allocation is
// refused in any cycle that empties the buffer.
module reorder_buffer
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int DEST_W = 32,
    parameter int NUM_LK = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_valid,
    input  logic [1:0]                    alloc_kind,
    input  logic [DEST_W-1:0]             alloc_dest,
    output logic                          alloc_ready,
    output logic [IDX_W-1:0]              alloc_tag,
    input  logic                          wb_valid,
    input  logic [IDX_W-1:0]              wb_tag,
    input  logic [DATA_W-1:0]             wb_value,
    input  logic                          wb_mispredict,
    input  logic                          wb_exc,
    input  logic [NUM_LK-1:0][IDX_W-1:0]  lk_tag,
    output logic [NUM_LK-1:0][DATA_W-1:0] lk_value,
    output logic [NUM_LK-1:0]             lk_ready,
    output logic                          cm_retire,
    output logic                          cm_reg_we,
    output logic [DEST_W-1:0]             cm_reg_dest,
    output logic [DATA_W-1:0]             cm_reg_data,
    output logic                          cm_mem_we,
    output logic [DEST_W-1:0]             cm_mem_addr,
    output logic [DATA_W-1:0]             cm_mem_data,
    output logic                          flush_valid,
    output logic [DATA_W-1:0]             flush_target,
    output logic                          exc_valid,
    output logic [IDX_W-1:0]              exc_tag
);
    logic              full, clear, alloc_fire;
    logic [IDX_W-1:0]  head_idx, tail_idx;
    logic              head_busy, head_ready, head_misp, head_exc;
    rob_kind_e         head_kind;
    logic [DEST_W-1:0] head_dest, cm_dest;
    logic [DATA_W-1:0] head_value, cm_data;
    logic [DEPTH-1:0]  busy_vec;

    // Grant when a slot is free and no flush empties the buffer
    assign alloc_ready = !full && !clear;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail_idx;

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (alloc_fire),
        .pop      (cm_retire),
        .clear    (clear),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (full)
    );

    rob_storage #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .NUM_LK(NUM_LK)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_en      (alloc_fire),
        .alloc_idx     (tail_idx),
        .alloc_kind    (rob_kind_e'(alloc_kind)),
        .alloc_dest    (alloc_dest),
        .wb_valid      (wb_valid),
        .wb_tag        (wb_tag),
        .wb_value      (wb_value),
        .wb_mispredict (wb_mispredict),
        .wb_exc        (wb_exc),
        .retire_en     (cm_retire),
        .clear_all     (clear),
        .head_idx      (head_idx),
        .lk_tag        (lk_tag),
        .lk_value      (lk_value),
        .lk_ready      (lk_ready),
        .head_busy     (head_busy),
        .head_ready    (head_ready),
        .head_kind     (head_kind),
        .head_dest     (head_dest),
        .head_value    (head_value),
        .head_misp     (head_misp),
        .head_exc      (head_exc),
        .busy_vec      (busy_vec)
    );

    rob_commit #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_commit (
        .head_busy  (head_busy),
        .head_ready (head_ready),
        .head_kind  (head_kind),
        .head_dest  (head_dest),
        .head_value (head_value),
        .head_misp  (head_misp),
        .head_exc   (head_exc),
        .head_idx   (head_idx),
        .retire     (cm_retire),
        .clear      (clear),
        .reg_we     (cm_reg_we),
        .mem_we     (cm_mem_we),
        .flush      (flush_valid),
        .exc        (exc_valid),
        .dest       (cm_dest),
        .data       (cm_data),
        .exc_idx    (exc_tag)
    );

    // Commit buses share the head destination and value
    assign cm_reg_dest  = cm_dest;
    assign cm_reg_data  = cm_data;
    assign cm_mem_addr  = cm_dest;
    assign cm_mem_data  = cm_data;
    assign flush_target = cm_data;
endmodule

// Checker: temporal properties of the reorder buffer, bound to the top.
module rob_checker
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ready,
    input logic [DEPTH-1:0] busy_vec,
    input logic [IDX_W-1:0] head_idx,
    input logic             head_ready,
    input rob_kind_e        head_kind,
    input logic             cm_retire,
    input logic             cm_reg_we,
    input logic             cm_mem_we,
    input logic             flush_valid,
    input logic             exc_valid
);
    p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(busy_vec) == DEPTH) |-> !alloc_ready);

    p_commit_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_reg_we || cm_mem_we) |-> head_ready);

    p_single_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cm_reg_we, cm_mem_we, flush_valid, exc_valid}));

    p_head_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cm_retire |=> head_idx == IDX_W'($past(head_idx) + 1'b1));

    p_store_at_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cm_mem_we |-> head_kind == ROB_STORE);

    p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> busy_vec == '0);

    p_fault_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !(cm_reg_we || cm_mem_we));

    p_fault_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> busy_vec == '0);
endmodule

bind reorder_buffer rob_checker #(.DEPTH(DEPTH)) u_rob_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_ready (alloc_ready),
    .busy_vec    (busy_vec),
    .head_idx    (head_idx),
    .head_ready  (head_ready),
    .head_kind   (head_kind),
    .cm_retire   (cm_retire),
    .cm_reg_we   (cm_reg_we),
    .cm_mem_we   (cm_mem_we),
    .flush_valid (flush_valid),
    .exc_valid   (exc_valid)
);

// File: tb/test_reorder_buffer.sv
`timescale 1ns/1ps
module test_reorder_buffer;
    localparam int DEPTH = 4, DATA_W = 16, DEST_W = 8, NUM_LK = 2, IDX_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [1:0] alloc_kind = 2'b00;
    logic [DEST_W-1:0] alloc_dest = '0;
    logic alloc_ready;
    logic [IDX_W-1:0] alloc_tag;
    logic wb_valid = 1'b0, wb_mispredict = 1'b0, wb_exc = 1'b0;
    logic [IDX_W-1:0] wb_tag = '0;
    logic [DATA_W-1:0] wb_value = '0;
    logic [NUM_LK-1:0][IDX_W-1:0] lk_tag = '0;
    logic [NUM_LK-1:0][DATA_W-1:0] lk_value;
    logic [NUM_LK-1:0] lk_ready;
    logic cm_retire, cm_reg_we, cm_mem_we, flush_valid, exc_valid;
    logic [DEST_W-1:0] cm_reg_dest, cm_mem_addr;
    logic [DATA_W-1:0] cm_reg_data, cm_mem_data, flush_target;
    logic [IDX_W-1:0] exc_tag;

    int checks = 0, errors = 0;

    // Event kinds: 0 reg write, 1 mem write, 2 plain retire, 3 flush, 4 fault
    typedef struct packed {
        logic [2:0]        k;
        logic [DEST_W-1:0] a;
        logic [DATA_W-1:0] d;
    } ev_t;
    ev_t exp_q[$];

    always #4 clk = ~clk;

    reorder_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .NUM_LK(NUM_LK))
    i_reorder_buffer (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
        .wb_mispredict(wb_mispredict), .wb_exc(wb_exc),
        .lk_tag(lk_tag), .lk_value(lk_value), .lk_ready(lk_ready),
        .cm_retire(cm_retire), .cm_reg_we(cm_reg_we), .cm_reg_dest(cm_reg_dest),
        .cm_reg_data(cm_reg_data), .cm_mem_we(cm_mem_we), .cm_mem_addr(cm_mem_addr),
        .cm_mem_data(cm_mem_data), .flush_valid(flush_valid), .flush_target(flush_target),
        .exc_valid(exc_valid), .exc_tag(exc_tag)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] k);
        case (k)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R7";
            3'd3: return "R6";
            default: return "R8";
        endcase
    endfunction

    // Driver: one allocation, checking the granted tag (R1)
    task automatic do_alloc(input logic [1:0] k, input logic [DEST_W-1:0] dst,
                            input logic [IDX_W-1:0] exp_tag);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_kind = k; alloc_dest = dst;
        #1;
        check("R1 ready", alloc_ready, 1);
        check("R1 tag", alloc_tag, exp_tag);
        @(posedge clk); #1;
        alloc_valid = 1'b0;
    endtask

    task automatic do_wb(input logic [IDX_W-1:0] t, input logic [DATA_W-1:0] v,
                         input logic mp, input logic ex);
        @(negedge clk);
        wb_valid = 1'b1; wb_tag = t; wb_value = v; wb_mispredict = mp; wb_exc = ex;
        @(posedge clk); #1;
        wb_valid = 1'b0; wb_mispredict = 1'b0; wb_exc = 1'b0;
    endtask

    task automatic expect_ev(input logic [2:0] k, input logic [DEST_W-1:0] a,
                             input logic [DATA_W-1:0] d);
        exp_q.push_back('{k: k, a: a, d: d});
    endtask

    // Monitor: commit outputs come from registered state, one event per cycle
    always @(negedge clk) begin
        if (rst_n && cm_retire) begin
            ev_t got, want;
            if (exc_valid)        got = '{k: 3'd4, a: DEST_W'(exc_tag), d: '0};
            else if (flush_valid) got = '{k: 3'd3, a: '0, d: flush_target};
            else if (cm_mem_we)   got = '{k: 3'd1, a: cm_mem_addr, d: cm_mem_data};
            else if (cm_reg_we)   got = '{k: 3'd0, a: cm_reg_dest, d: cm_reg_data};
            else                  got = '{k: 3'd2, a: '0, d: '0};
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected commit actual %0h expected none",
                         req_of(got.k), got);
            end else begin
                want = exp_q.pop_front();
                if (got != want) begin
                    errors++;
                    $display("FAIL %s: commit actual %0h expected %0h",
                             req_of(want.k), got, want);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 ready", alloc_ready, 1);
        check("R10 tag", alloc_tag, 0);
        check("R10 outputs", {cm_retire, cm_reg_we, cm_mem_we, flush_valid, exc_valid}, 0);

        // Fill: reg, store, reg, branch
        expect_ev(3'd0, 8'h11, 16'h1000);
        expect_ev(3'd1, 8'hA0, 16'h2000);
        expect_ev(3'd0, 8'h12, 16'h3000);
        expect_ev(3'd2, 8'h00, 16'h0000);
        do_alloc(2'b00, 8'h11, 2'd0);
        do_alloc(2'b01, 8'hA0, 2'd1);
        do_alloc(2'b00, 8'h12, 2'd2);
        do_alloc(2'b10, 8'h00, 2'd3);
        @(negedge clk);
        check("R2 full stall", alloc_ready, 0);
        // R2: a request while full is ignored
        alloc_valid = 1'b1; alloc_kind = 2'b00; alloc_dest = 8'hEE;
        @(posedge clk); #1 alloc_valid = 1'b0;

        // Out-of-order completion: younger result first
        do_wb(2'd2, 16'h3000, 1'b0, 1'b0);
        @(negedge clk);
        check("R4 no commit before head ready", cm_retire, 0);
        lk_tag[0] = 2'd2; lk_tag[1] = 2'd0;
        #1;
        check("R9 lookup value", lk_value[0], 16'h3000);
        check("R3 lookup ready", lk_ready[0], 1);
        check("R9 not ready", lk_ready[1], 0);
        // R9: forward a same-cycle broadcast (store data for slot 1)
        @(negedge clk);
        wb_valid = 1'b1; wb_tag = 2'd1; wb_value = 16'h2000;
        lk_tag[1] = 2'd1;
        #1;
        check("R9 forward ready", lk_ready[1], 1);
        check("R9 forward value", lk_value[1], 16'h2000);
        check("R5 store held", cm_mem_we, 0);
        @(posedge clk); #1 wb_valid = 1'b0;
        do_wb(2'd0, 16'h1000, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        do_wb(2'd3, 16'h0055, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 queue drained", exp_q.size(), 0);
        check("R2 ignored request left tail", alloc_tag, 0);

        // Mispredicted branch with younger completed work behind it
        expect_ev(3'd0, 8'h21, 16'h4444);
        expect_ev(3'd3, 8'h00, 16'h0400);
        do_alloc(2'b00, 8'h21, 2'd0);
        do_alloc(2'b10, 8'h00, 2'd1);
        do_alloc(2'b00, 8'h22, 2'd2);
        do_alloc(2'b01, 8'hB0, 2'd3);
        do_wb(2'd2, 16'h7777, 1'b0, 1'b1);
        do_wb(2'd3, 16'h8888, 1'b0, 1'b0);
        do_wb(2'd1, 16'h0400, 1'b1, 1'b0);
        do_wb(2'd0, 16'h4444, 1'b0, 1'b0);
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R6 flush events", exp_q.size(), 0);
        check("R6 ready after flush", alloc_ready, 1);
        check("R6 tag after branch", alloc_tag, 2);

        // Fault at head, then normal work resumes
        expect_ev(3'd4, 8'h02, 16'h0000);
        expect_ev(3'd0, 8'h32, 16'hABCD);
        do_alloc(2'b00, 8'h31, 2'd2);
        do_wb(2'd2, 16'h9999, 1'b0, 1'b1);
        repeat (2) @(posedge clk);
        do_alloc(2'b00, 8'h32, 2'd3);
        do_wb(2'd3, 16'hABCD, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 fault events", exp_q.size(), 0);
        check("R1 wrap tag", alloc_tag, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule